// File: doc/BRIEF.md
# I2C Write-Only Host with Inter-Byte Flow Control

This block is an I2C bus master that only writes. It sends each transfer to one fixed slave address. A producer hands it data bytes one at a time over a valid/ready command port, and marks the final byte of a transfer with a last flag. The first accepted byte opens a transfer. The block then emits a start condition, the address byte with the write bit cleared, and the data bytes. It closes with a stop condition once the last byte has been acknowledged.

Both bus lines are open-drain. The block only ever pulls a line low or releases it, and it reads the resolved level back. Each bit takes four quarter-periods, and a parameter sets the length of a quarter in system clocks. Between data bytes the block holds SCL low and will not take the next byte while the active-low busy input from the slave is low. It also waits whenever the slave holds SCL low after the master has released it, and only starts timing the high phase once SCL reads high.

A missing acknowledge on any byte means the link is corrupted. The block then ends the transfer with a stop and raises a sticky fatal flag, which tells the system to reboot the slave. A one-clock done pulse marks the completion of every stop, whether the transfer ended normally or after a fatal error.

Top module: `i2c_flow_writer`

## Requirements
- R1: While reset is asserted, and after it, both line pull-downs are off, linkFatal and xferDone are low, and cmdReady is high.
- R2: A transfer opens with SDA falling while SCL is high. SCL is next pulled low no sooner than QDIV clocks after that fall.
- R3: The first byte on the wire is the slave address SLV_ADDR (default 7'b1000000) in bits 7..1 with bit 0 = 0 for write, so 0x80 by default.
- R4: Each data byte goes out on the wire most-significant bit first, in the order the bytes were accepted. After every byte the master releases SDA for a ninth clock, and the slave acknowledges by pulling SDA low.
- R5: Apart from the start and stop conditions, SDA changes only while SCL is low. No extra start or stop appears inside a transfer.
- R6: After an acknowledged byte that was not marked last, SCL stays low. While slaveBusyN is low, cmdReady stays low and no SCL pulse is issued.
- R7: If the slave holds SCL low after it has been released, the master waits. Every SCL high phase lasts at least 2*QDIV clocks, counted from the moment SCL reads high.
- R8: If SDA reads high during a ninth clock, the master sends a stop, sets linkFatal and sends no further byte. linkFatal stays high until the next command is accepted, and no bytes offered after the failure are taken into that transfer.
- R9: After the acknowledged last byte, the master sends a stop (SDA rising while SCL is high). xferDone then pulses high for exactly one clock, with both lines released and cmdReady high.
- R10: Accepting the first byte of a new transfer clears linkFatal in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command byte offered |
| cmdData | input | 8 | Data byte to send |
| cmdLast | input | 1 | Offered byte ends the transfer |
| cmdReady | output | 1 | Byte is taken on a clock where cmdValid is also high |
| slaveBusyN | input | 1 | Slave ready level; low pauses before the next byte |
| sclIn | input | 1 | Resolved SCL level, synchronised |
| sdaIn | input | 1 | Resolved SDA level, synchronised |
| sclDriveLow | output | 1 | Pull SCL low when high |
| sdaDriveLow | output | 1 | Pull SDA low when high |
| linkFatal | output | 1 | Sticky error: a byte was not acknowledged |
| xferDone | output | 1 | One-clock pulse after a stop completes |

## Verification
If the phase or slot counter ends up in a wrong state, it shows at the pins within one bit time (4*QDIV clocks). The bench model sees it as a corrupted byte, a missing or spurious ninth clock, or an SDA edge while SCL is high, which it decodes as a stray start or stop. If the sticky error or the gating logic goes wrong, it shows up within one clock on linkFatal, on cmdReady while slaveBusyN is low, or on SCL pulses during a pause. Shortened high phases or a start hold that is too short show up in cycle counts the bench measures on every edge.

// File: rtl/i2c_flow_pkg.sv
package i2c_flow_pkg;

  localparam int BYTE_BITS = 8;

  // What the controller asks of the SDA driver in a given cycle
  typedef enum logic [1:0] {
    SDA_KEEP = 2'd0,
    SDA_REL  = 2'd1,
    SDA_LOW  = 2'd2,
    SDA_BIT  = 2'd3
  } sdaSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    sclPull;
    sdaSel_e sdaSel;
    logic    loadAddr;
    logic    capCmd;
    logic    loadPend;
    logic    shiftOut;
    logic    sampleAck;
    logic    slotClr;
  } lineStrb_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_STA_SU,
    S_STA_HD,
    S_LOAD,
    S_BIT,
    S_WAIT,
    S_STO_A,
    S_STO_B,
    S_STO_C,
    S_STO_D
  } ctlState_e;

endpackage

// File: rtl/i2c_flow_qtimer.sv
module i2c_flow_qtimer #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic hold,
  output logic tick
);

  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !restart && !hold && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else if (!hold)           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/i2c_flow_datapath.sv
module i2c_flow_datapath
  import i2c_flow_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'b1000000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lineStrb_t            strb,
  input  logic [BYTE_BITS-1:0] cmdData,
  input  logic                 cmdLast,
  input  logic                 sdaIn,
  output logic                 sclDriveLow,
  output logic                 sdaDriveLow,
  output logic                 pendLast,
  output logic                 ackMiss,
  output logic                 ackSlot
);

  localparam int SLOT_W = $clog2(BYTE_BITS + 2);
  localparam logic [BYTE_BITS-1:0] ADDR_BYTE = {SLV_ADDR, 1'b0};

  logic [BYTE_BITS-1:0] shiftReg;
  logic [BYTE_BITS-1:0] pendReg;
  logic [SLOT_W-1:0]    slotCnt;

  assign ackSlot = (slotCnt == SLOT_W'(BYTE_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      pendReg     <= '0;
      pendLast    <= 1'b0;
      slotCnt     <= '0;
      ackMiss     <= 1'b0;
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      if (strb.capCmd) begin
        pendReg  <= cmdData;
        pendLast <= cmdLast;
      end
      if (strb.loadAddr)      shiftReg <= ADDR_BYTE;
      else if (strb.loadPend) shiftReg <= pendReg;
      else if (strb.shiftOut) shiftReg <= {shiftReg[BYTE_BITS-2:0], 1'b0};

      if (strb.slotClr)       slotCnt <= '0;
      else if (strb.shiftOut) slotCnt <= slotCnt + 1'b1;

      if (strb.sampleAck) ackMiss <= sdaIn;

      sclDriveLow <= strb.sclPull;
      case (strb.sdaSel)
        SDA_REL:  sdaDriveLow <= 1'b0;
        SDA_LOW:  sdaDriveLow <= 1'b1;
        SDA_BIT:  sdaDriveLow <= ~shiftReg[BYTE_BITS-1];
        default:  sdaDriveLow <= sdaDriveLow;
      endcase
    end
  end

endmodule

// File: rtl/i2c_flow_ctrl.sv
module i2c_flow_ctrl
  import i2c_flow_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      slaveBusyN,
  input  logic      sclIn,
  input  logic      tick,
  input  logic      ackMiss,
  input  logic      ackSlot,
  input  logic      pendLast,
  output lineStrb_t strb,
  output logic      tmrRestart,
  output logic      tmrHold,
  output logic      cmdReady,
  output logic      linkFatal,
  output logic      xferDone
);

  ctlState_e st, stNx;
  logic [1:0] ph, phNx;
  logic isAddr, isAddrNx;
  logic fatalNx, doneNx;
  logic accept;

  assign cmdReady = (st == S_IDLE) || ((st == S_WAIT) && slaveBusyN);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    stNx        = st;
    phNx        = ph;
    isAddrNx    = isAddr;
    fatalNx     = linkFatal;
    doneNx      = 1'b0;
    strb        = '0;
    strb.sclPull = 1'b1;
    strb.sdaSel = SDA_KEEP;
    tmrRestart  = 1'b0;
    tmrHold     = 1'b0;
    case (st)
      S_IDLE: begin
        strb.sclPull = 1'b0;
        strb.sdaSel  = SDA_REL;
        tmrRestart   = 1'b1;
        if (accept) begin
          strb.capCmd   = 1'b1;
          strb.loadAddr = 1'b1;
          strb.slotClr  = 1'b1;
          fatalNx       = 1'b0;
          isAddrNx      = 1'b1;
          stNx          = S_STA_SU;
        end
      end
      S_STA_SU: begin
        strb.sclPull = 1'b0;
        strb.sdaSel  = SDA_REL;
        if (tick) stNx = S_STA_HD;
      end
      S_STA_HD: begin
        strb.sclPull = 1'b0;
        strb.sdaSel  = SDA_LOW;
        if (tick) begin
          stNx = S_BIT;
          phNx = 2'd0;
        end
      end
      S_LOAD: begin
        tmrRestart    = 1'b1;
        strb.loadPend = 1'b1;
        strb.slotClr  = 1'b1;
        stNx          = S_BIT;
        phNx          = 2'd0;
      end
      S_BIT: begin
        strb.sclPull = (ph < 2'd2);
        if (ph == 2'd1) strb.sdaSel = ackSlot ? SDA_REL : SDA_BIT;
        tmrHold = (ph >= 2'd2) && !sclIn;
        if (tick) begin
          phNx = ph + 2'd1;
          if ((ph == 2'd2) && ackSlot) strb.sampleAck = 1'b1;
          if (ph == 2'd3) begin
            strb.shiftOut = 1'b1;
            if (ackSlot) begin
              if (ackMiss) begin
                fatalNx = 1'b1;
                stNx    = S_STO_A;
              end else if (isAddr) begin
                isAddrNx = 1'b0;
                stNx     = S_LOAD;
              end else if (pendLast) begin
                stNx = S_STO_A;
              end else begin
                stNx = S_WAIT;
              end
            end
          end
        end
      end
      S_WAIT: begin
        tmrRestart = 1'b1;
        if (accept) begin
          strb.capCmd = 1'b1;
          stNx        = S_LOAD;
        end
      end
      S_STO_A: begin
        if (tick) stNx = S_STO_B;
      end
      S_STO_B: begin
        strb.sdaSel = SDA_LOW;
        if (tick) stNx = S_STO_C;
      end
      S_STO_C: begin
        strb.sclPull = 1'b0;
        tmrHold      = !sclIn;
        if (tick) stNx = S_STO_D;
      end
      S_STO_D: begin
        strb.sclPull = 1'b0;
        strb.sdaSel  = SDA_REL;
        if (tick) begin
          stNx   = S_IDLE;
          doneNx = 1'b1;
        end
      end
      default: stNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_IDLE;
      ph        <= 2'd0;
      isAddr    <= 1'b0;
      linkFatal <= 1'b0;
      xferDone  <= 1'b0;
    end else begin
      st        <= stNx;
      ph        <= phNx;
      isAddr    <= isAddrNx;
      linkFatal <= fatalNx;
      xferDone  <= doneNx;
    end
  end

endmodule

// File: rtl/i2c_flow_writer.sv
module i2c_flow_writer
  import i2c_flow_pkg::*;
#(
  parameter int         QDIV     = 4,
  parameter logic [6:0] SLV_ADDR = 7'b1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdData,
  input  logic       cmdLast,
  output logic       cmdReady,
  input  logic       slaveBusyN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       linkFatal,
  output logic       xferDone
);

  lineStrb_t strb;
  logic tmrRestart, tmrHold, tick;
  logic ackMiss, ackSlot, pendLast;

  i2c_flow_qtimer #(.QDIV(QDIV)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .restart (tmrRestart),
    .hold    (tmrHold),
    .tick    (tick)
  );

  i2c_flow_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .slaveBusyN (slaveBusyN),
    .sclIn      (sclIn),
    .tick       (tick),
    .ackMiss    (ackMiss),
    .ackSlot    (ackSlot),
    .pendLast   (pendLast),
    .strb       (strb),
    .tmrRestart (tmrRestart),
    .tmrHold    (tmrHold),
    .cmdReady   (cmdReady),
    .linkFatal  (linkFatal),
    .xferDone   (xferDone)
  );

  i2c_flow_datapath #(.SLV_ADDR(SLV_ADDR)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cmdData     (cmdData),
    .cmdLast     (cmdLast),
    .sdaIn       (sdaIn),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .pendLast    (pendLast),
    .ackMiss     (ackMiss),
    .ackSlot     (ackSlot)
  );

endmodule

// File: rtl/i2c_flow_writer_chk.sv
module i2c_flow_writer_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic slaveBusyN,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic linkFatal,
  input logic xferDone
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!sclDriveLow && !sdaDriveLow && !linkFatal && !xferDone);
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (cmdReady && !sclDriveLow && !sdaDriveLow));

  // R6
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !slaveBusyN) |-> (!sclDriveLow && !sdaDriveLow));

  // R8
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkFatal && !(cmdValid && cmdReady)) |=> linkFatal);

  // R10
  fatal_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !linkFatal);

endmodule

bind i2c_flow_writer i2c_flow_writer_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .slaveBusyN  (slaveBusyN),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow),
  .linkFatal   (linkFatal),
  .xferDone    (xferDone)
);

// File: tb/i2c_flow_writer_bench.sv
module i2c_flow_writer_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int QDIV        = 4;
  localparam int WATCHDOG    = 100000;
  localparam int STRETCH_CYC = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       cmdValid = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic       cmdLast = 1'b0;
  logic       slaveBusyN = 1'b1;
  logic       cmdReady, sclDriveLow, sdaDriveLow, linkFatal, xferDone;
  logic       stretchLow = 1'b0;
  logic       slvSdaLow = 1'b0;
  logic       sclBus, sdaBus;

  assign sclBus = !(sclDriveLow || stretchLow);
  assign sdaBus = !(sdaDriveLow || slvSdaLow);

  i2c_flow_writer #(.QDIV(QDIV)) u_i2c_flow_writer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData), .cmdLast(cmdLast),
    .cmdReady(cmdReady), .slaveBusyN(slaveBusyN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .linkFatal(linkFatal),
    .xferDone(xferDone)
  );

  int checks = 0;
  int fails = 0;
  byte unsigned expQ[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- slave model and monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc++;

  int doneCnt = 0;
  always @(posedge clk) if (xferDone) doneCnt++;

  bit prevScl = 1'b1, prevSda = 1'b1, inXfer = 1'b0, ackDrive = 1'b0;
  bit startPending = 1'b0, riseValid = 1'b0, stretchEn = 1'b0;
  int bitCnt = 0, byteIdx = 0, nackAt = -1;
  int stopCnt = 0, startCnt = 0, sclRises = 0, stretchReqs = 0;
  int startCyc = 0, riseCyc = 0, minHold = 100000, minHigh = 100000;
  logic [7:0] rxByte = 8'h00;

  always @(sclBus, sdaBus) begin
    if (sclBus && prevScl && prevSda && !sdaBus) begin
      inXfer = 1'b1; bitCnt = 0; byteIdx = 0; ackDrive = 1'b0;
      startCnt++; startCyc = cyc; startPending = 1'b1; riseValid = 1'b0;
    end else if (sclBus && prevScl && !prevSda && sdaBus) begin
      if (inXfer) stopCnt++;
      inXfer = 1'b0;
    end
    if (!prevScl && sclBus) begin
      sclRises++;
      riseCyc = cyc;
      riseValid = 1'b1;
      if (inXfer && !ackDrive && bitCnt < 8) begin
        rxByte = {rxByte[6:0], sdaBus};
        bitCnt++;
      end
    end
    if (prevScl && !sclBus) begin
      if (startPending) begin
        startPending = 1'b0;
        if (cyc - startCyc < minHold) minHold = cyc - startCyc;
      end
      if (riseValid && (cyc - riseCyc < minHigh)) minHigh = cyc - riseCyc;
      riseValid = 1'b0;
      if (inXfer) begin
        if (ackDrive) begin
          slvSdaLow = 1'b0; ackDrive = 1'b0; bitCnt = 0; byteIdx++;
          if (stretchEn) stretchReqs++;
        end else if (bitCnt == 8) begin
          if (expQ.size() == 0) begin
            check(1'b0, (byteIdx == 0) ? "R3" : "R4", "unexpected byte", rxByte, 0);
          end else begin
            byte unsigned e;
            e = expQ.pop_front();
            check(rxByte == e, (byteIdx == 0) ? "R3" : "R4", "byte on wire", rxByte, e);
          end
          slvSdaLow = (byteIdx != nackAt);
          ackDrive = 1'b1;
        end
      end
    end
    prevScl = sclBus;
    prevSda = sdaBus;
  end

  int stretchDone = 0, stretchLeft = 0;
  always @(posedge clk) begin
    if (stretchLeft > 0) begin
      stretchLeft--;
      if (stretchLeft == 0) stretchLow <= 1'b0;
    end else if (stretchDone != stretchReqs) begin
      stretchDone++;
      stretchLeft = STRETCH_CYC;
      stretchLow <= 1'b1;
    end
  end

  // ---------------- driver ----------------
  task automatic offer(input byte unsigned b, input bit last, input bit first, output bit taken);
    taken = 1'b0;
    @(negedge clk);
    cmdValid = 1'b1; cmdData = b; cmdLast = last;
    forever begin
      if (!first && linkFatal) begin
        cmdValid = 1'b0;
        return;
      end
      if (cmdReady) begin
        if (first) expQ.push_back(8'h80);
        expQ.push_back(b);
        @(posedge clk);
        taken = 1'b1;
        @(negedge clk);
        cmdValid = 1'b0;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic runXfer(input byte unsigned d[$], input int nackIdx, input bit stretch,
                         input int busyGap, input bit expectFatal);
    int d0, s0, st0, rises0;
    bit taken, readySeen;
    d0 = doneCnt; s0 = stopCnt; st0 = startCnt;
    nackAt = nackIdx; stretchEn = stretch;
    for (int i = 0; i < d.size(); i++) begin
      if (i > 0 && busyGap > 0) begin
        slaveBusyN = 1'b0;
        repeat (400 + (stretch ? 100 : 0)) @(negedge clk);
        rises0 = sclRises; readySeen = 1'b0;
        for (int k = 0; k < busyGap; k++) begin
          @(negedge clk);
          if (cmdReady) readySeen = 1'b1;
        end
        check(!readySeen, "R6", "cmdReady while busy", readySeen, 0);
        check(sclRises == rises0, "R6", "SCL pulses while busy", sclRises - rises0, 0);
        slaveBusyN = 1'b1;
      end
      offer(d[i], (i == d.size() - 1), (i == 0), taken);
      if (!taken) break;
      if (i == 0) check(!linkFatal, "R10", "fatal after new start", linkFatal, 0);
    end
    for (int t = 0; t < 20000 && doneCnt == d0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(doneCnt == d0 + 1, "R9", "done pulse cycles", doneCnt - d0, 1);
    check(stopCnt == s0 + 1, "R9", "stop conditions", stopCnt - s0, 1);
    check(startCnt == st0 + 1, "R5", "start conditions", startCnt - st0, 1);
    check(expQ.size() == 0, expectFatal ? "R8" : "R4", "bytes missing", expQ.size(), 0);
    check(linkFatal == expectFatal, "R8", "linkFatal", linkFatal, expectFatal);
    check(cmdReady && !sclDriveLow && !sdaDriveLow, "R9", "idle after stop",
          {cmdReady, sclDriveLow, sdaDriveLow}, 3'b100);
    expQ.delete();
    stretchEn = 1'b0;
    nackAt = -1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    byte unsigned q[$];
    repeat (4) @(negedge clk);
    // R1: state under reset
    check(!sclDriveLow && !sdaDriveLow, "R1", "lines in reset", {sclDriveLow, sdaDriveLow}, 0);
    check(!linkFatal && !xferDone, "R1", "flags in reset", {linkFatal, xferDone}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(cmdReady, "R1", "cmdReady after reset", cmdReady, 1);

    // single byte, R3/R4/R9
    q = '{8'hA5};
    runXfer(q, -1, 1'b0, 0, 1'b0);
    // multi-byte with clock stretching, R7
    q = '{8'h01, 8'hFE, 8'h3C};
    runXfer(q, -1, 1'b1, 0, 1'b0);
    check(stretchDone > 0, "R7", "stretch applied", stretchDone, 1);
    // busy gating between bytes, R6
    q = '{8'h55, 8'hAA, 8'h0F};
    runXfer(q, -1, 1'b0, 60, 1'b0);
    // NACK on second data byte, R8
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    runXfer(q, 2, 1'b0, 0, 1'b1);
    repeat (50) @(negedge clk);
    check(linkFatal, "R8", "fatal held while idle", linkFatal, 1);
    // clean transfer after fatal, R10
    q = '{8'h7E, 8'h81};
    runXfer(q, -1, 1'b0, 0, 1'b0);

    check(minHold >= QDIV, "R2", "start hold clocks", minHold, QDIV);
    check(minHigh >= 2 * QDIV, "R7", "min SCL high clocks", minHigh, 2 * QDIV);
    summary();
    $finish;
  end

endmodule